// File: doc/BRIEF.md
# Codec Configuration Sequencer

After reset this block programs an audio codec by pushing a short, fixed list of 16-bit configuration words into a serial transmitter, one word at a time. For each word it raises a one-cycle load strobe and holds the word on its data output. It then waits for the transmitter to report that the word has been shifted out, and only after that does it move on. The list opens with silent padding frames. Each of the two register writes comes right after its own control-request word. The list ends with more padding.

The two register writes set the codec's clock dividers. Divider A, in register 1, fixes the frame clock at the master clock divided by 2·A. Divider B, in register 2, fixes the sample rate at the frame clock divided by B. With the default values A = 35 and B = 15 and a 10 MHz master clock, this gives roughly 142.857 kHz frames and roughly 9.524 kHz sampling. When the last word is acknowledged, the block raises a sticky done flag so that sample streaming can start. It then stays idle until the next reset.

Top module: `codec_init_seq`

## Requirements
- R1: While rst_n is low, tx_load and cfg_done are low. The first rising edge with rst_n high moves the block into its first load, so tx_load is high in the following cycle with entry 0 on tx_data.
- R2: tx_load is high for exactly one cycle per entry, and exactly 9 load pulses occur between a reset release and cfg_done.
- R3: The entries are sent in this order: 0x0000, 0x0000, 0x0003, 0x0123, 0x0003, 0x020F, 0x0000, 0x0000, 0x0000. 0x0000 is a padding word and 0x0003 (low two bits set) is a control request. A register write carries the register number in bits 15:8 and the value in bits 7:0.
- R4: Register 1 receives divider A = 35 and register 2 receives divider B = 15. With a 10 MHz master clock, the integer frame rate 10,000,000/(2·A) is 142857 Hz and the integer sample rate 10,000,000/(2·A·B) is 9523 Hz.
- R5: tx_data holds its value from the load cycle until the cycle in which tx_complete is accepted.
- R6: A tx_complete that is high in the same cycle as tx_load is ignored. The entry does not advance and no new load follows in the next cycle.
- R7: When tx_complete is high in a cycle after the load cycle of an entry other than the last, tx_load is high in the next cycle with the next entry.
- R8: When tx_complete is accepted for the last entry, cfg_done is high from the next cycle on and stays high until reset. After that, tx_load stays low and tx_complete has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_complete | input | 1 | Transmitter reports that the current word has been sent |
| tx_load | output | 1 | One-cycle strobe handing tx_data to the transmitter |
| tx_data | output | 16 | Configuration word being sent |
| cfg_done | output | 1 | All entries sent; sticky until reset |

## Verification
The two events that can fall in the same cycle are the load strobe of an entry and a completion indication from the transmitter. The bench provokes this on purpose by raising tx_complete during the load cycle of entry 1. It then judges the result at the ports: in the next cycle tx_load must be low and the same word must still be on tx_data. The entry may advance only on a later completion. A second coincidence is completion pulses arriving after cfg_done, which must leave both tx_load and cfg_done unchanged.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  localparam int CW_WORD = 16;
  localparam int CW_FIELD = CW_WORD / 2;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  function automatic logic [CW_WORD-1:0] pad_word();
    return '0;
  endfunction

  function automatic logic [CW_WORD-1:0] request_word();
    return CW_WORD'(3);
  endfunction

  function automatic logic [CW_WORD-1:0] write_word(input logic [CW_FIELD-1:0] regnum,
                                                    input logic [CW_FIELD-1:0] value);
    return {regnum, value};
  endfunction

  // Length of the list: leading pads, one request+write pair per divider, trailing pads.
  function automatic int table_len(input int lead, input int tail);
    return lead + 4 + tail;
  endfunction

  function automatic logic [CW_WORD-1:0] entry_word(input int idx, input int lead,
                                                    input logic [CW_FIELD-1:0] div_a,
                                                    input logic [CW_FIELD-1:0] div_b);
    int rel;
    rel = idx - lead;
    if (rel < 0) return pad_word();
    case (rel)
      0:       return request_word();
      1:       return write_word(CW_FIELD'(1), div_a);
      2:       return request_word();
      3:       return write_word(CW_FIELD'(2), div_b);
      default: return pad_word();
    endcase
  endfunction

  function automatic int unsigned frame_rate_hz(input int unsigned mclk_hz, input int unsigned div_a);
    return mclk_hz / (2 * div_a);
  endfunction

  function automatic int unsigned sample_rate_hz(input int unsigned mclk_hz, input int unsigned div_a,
                                                 input int unsigned div_b);
    return frame_rate_hz(mclk_hz, div_a) / div_b;
  endfunction

endpackage

// File: rtl/codec_seq_rom.sv
module codec_seq_rom
  import codec_seq_pkg::*;
#(
  parameter int ENTRIES  = 9,
  parameter int LEAD_PAD = 2,
  parameter int IDX_W    = 4,
  parameter logic [CW_FIELD-1:0] DIV_A = 8'd35,
  parameter logic [CW_FIELD-1:0] DIV_B = 8'd15
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [CW_WORD-1:0] word
);

  logic [CW_WORD-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign tbl[g] = entry_word(g, LEAD_PAD, DIV_A, DIV_B);
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (idx == IDX_W'(k)) word = tbl[k];
    end
  end

endmodule

// File: rtl/codec_seq_ptr.sv
module codec_seq_ptr #(
  parameter int ENTRIES = 9,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end

  assign at_last = (idx == LAST_IDX);

endmodule

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
  import codec_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_complete,
  input  logic at_last,
  output logic load,
  output logic accept,
  output logic step,
  output logic done
);

  seq_state_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_START;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_START: nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_WAIT;
      ST_WAIT:  if (tx_complete) nxt = at_last ? ST_DONE : ST_LOAD;
      default:  nxt = ST_DONE;
    endcase
  end

  assign load   = (state == ST_LOAD);
  assign accept = (state == ST_WAIT) && tx_complete;
  assign step   = accept && !at_last;
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_seq_pkg::*;
#(
  parameter int LEAD_PAD = 2,
  parameter int TAIL_PAD = 3,
  parameter logic [CW_FIELD-1:0] DIV_A = 8'd35,
  parameter logic [CW_FIELD-1:0] DIV_B = 8'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_complete,
  output logic               tx_load,
  output logic [CW_WORD-1:0] tx_data,
  output logic               cfg_done
);

  localparam int ENTRIES = table_len(LEAD_PAD, TAIL_PAD);
  localparam int IDX_W   = $clog2(ENTRIES);

  // Named internal events, visible to the bound checker.
  logic             word_accept;
  logic             ptr_step;
  logic             last_entry;
  logic [IDX_W-1:0] entry_idx;

  codec_seq_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_complete(tx_complete),
    .at_last    (last_entry),
    .load       (tx_load),
    .accept     (word_accept),
    .step       (ptr_step),
    .done       (cfg_done)
  );

  codec_seq_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (ptr_step),
    .idx    (entry_idx),
    .at_last(last_entry)
  );

  codec_seq_rom #(
    .ENTRIES (ENTRIES),
    .LEAD_PAD(LEAD_PAD),
    .IDX_W   (IDX_W),
    .DIV_A   (DIV_A),
    .DIV_B   (DIV_B)
  ) i_rom (
    .idx (entry_idx),
    .word(tx_data)
  );

endmodule

// File: rtl/codec_seq_checker.sv
module codec_seq_checker #(
  parameter int ENTRIES = 9
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_load,
  input logic        tx_complete,
  input logic [15:0] tx_data,
  input logic        cfg_done,
  input logic        accept,
  input logic        at_last
);

  logic [7:0] load_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_cnt <= '0;
    else if (tx_load) load_cnt <= load_cnt + 1'b1;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);

  a_r2_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    load_cnt <= 8'(ENTRIES));

  a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !cfg_done) |=> $stable(tx_data));

  a_r6_coincide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_complete) |=> (!tx_load && $stable(tx_data)));

  a_r7_next_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !at_last) |=> tx_load);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !tx_load);

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && at_last) |=> (cfg_done && load_cnt == 8'(ENTRIES)));

endmodule

bind codec_init_seq codec_seq_checker #(.ENTRIES(ENTRIES)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_load    (tx_load),
  .tx_complete(tx_complete),
  .tx_data    (tx_data),
  .cfg_done   (cfg_done),
  .accept     (word_accept),
  .at_last    (last_entry)
);

// File: tb/test_codec_init_seq.sv
module test_codec_init_seq;

  localparam int NUM = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_complete = 1'b0;
  logic        tx_load;
  logic [15:0] tx_data;
  logic        cfg_done;

  int checks = 0;
  int errors = 0;
  bit reported = 0;
  int seen_a, seen_b;

  always #5 clk = ~clk;

  codec_init_seq i_codec_init_seq (
    .clk(clk), .rst_n(rst_n), .tx_complete(tx_complete),
    .tx_load(tx_load), .tx_data(tx_data), .cfg_done(cfg_done)
  );

  function automatic logic [15:0] exp_word(input int i);
    case (i)
      2, 4:    return 16'h0003;
      3:       return 16'h0100 | 16'd35;
      5:       return 16'h0200 | 16'd15;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tx_complete = 1'b0;
    @(negedge clk);
    chk(tx_load === 1'b0, "R1 load in reset", int'(tx_load), 0);
    chk(cfg_done === 1'b0, "R1 done in reset", int'(cfg_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_load === 1'b1, "R1 first load", int'(tx_load), 1);
    chk(tx_data === exp_word(0), "R1 entry 0", int'(tx_data), int'(exp_word(0)));
  endtask

  // Entered at the negedge of a load cycle; leaves at the negedge after completion.
  task automatic run_sequence(input bit coincide);
    logic [15:0] held;
    int d;
    int loads = 0;
    for (int i = 0; i < NUM; i++) begin
      chk(tx_load === 1'b1, "R2 load present", int'(tx_load), 1);
      chk(tx_data === exp_word(i), "R3 word order", int'(tx_data), int'(exp_word(i)));
      if (tx_data[15:8] == 8'd1) seen_a = int'(tx_data[7:0]);
      if (tx_data[15:8] == 8'd2) seen_b = int'(tx_data[7:0]);
      held = tx_data;
      loads++;
      if (coincide && i == 1) tx_complete = 1'b1;
      @(negedge clk);
      tx_complete = 1'b0;
      if (coincide && i == 1)
        chk(tx_load === 1'b0 && tx_data === held, "R6 coincident complete", int'(tx_data), int'(held));
      else
        chk(tx_load === 1'b0, "R2 single-cycle load", int'(tx_load), 0);
      d = int'($urandom_range(0, 4));
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        chk(tx_load === 1'b0 && tx_data === held, "R5 word held", int'(tx_data), int'(held));
      end
      tx_complete = 1'b1;
      @(negedge clk);
      tx_complete = 1'b0;
      if (i < NUM - 1)
        chk(tx_load === 1'b1, "R7 next load", int'(tx_load), 1);
      else
        chk(cfg_done === 1'b1 && tx_load === 1'b0, "R8 done raised", int'(cfg_done), 1);
    end
    chk(loads == NUM, "R2 load count", loads, NUM);
  endtask

  initial begin
    void'($urandom(32'd24680));
    do_reset();
    run_sequence(1'b1);

    // R4: decoded dividers and resulting integer rates.
    chk(seen_a == 35, "R4 divider A", seen_a, 35);
    chk(seen_b == 15, "R4 divider B", seen_b, 15);
    chk(10_000_000 / (seen_a * 2) == 142857, "R4 frame rate", 10_000_000 / (seen_a * 2), 142857);
    chk(10_000_000 / (seen_a * seen_b * 2) == 9523, "R4 sample rate",
        10_000_000 / (seen_a * seen_b * 2), 9523);

    // R8: completions after done have no effect.
    for (int k = 0; k < 6; k++) begin
      tx_complete = k[0];
      @(negedge clk);
      chk(cfg_done === 1'b1 && tx_load === 1'b0, "R8 idle after done", int'(tx_load), 0);
    end
    tx_complete = 1'b0;

    // Second full pass with fresh random spacing.
    do_reset();
    run_sequence(1'b0);

    // Reset in the middle of a wait restarts at entry 0.
    do_reset();
    @(negedge clk);
    tx_complete = 1'b1;
    @(negedge clk);
    tx_complete = 1'b0;
    chk(tx_data === exp_word(1), "R7 mid-sequence advance", int'(tx_data), int'(exp_word(1)));
    do_reset();
    chk(cfg_done === 1'b0, "R1 done clear after restart", int'(cfg_done), 0);

    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule